// File: doc/BRIEF.md
# Pipelined Bus Cycle Issue Controller

This block drives the master side of a processor-style bus that allows up to two cycles in flight. It starts a bus cycle by pulsing an address strobe for one clock, and it keeps a small queue that holds, for each outstanding cycle, the number of burst-ready returns still owed. The address, data and status contents of a cycle are handled elsewhere. This block only decides when a strobe may go out and when a cycle is finished.

When no cycle is outstanding, a pending request is issued on the next clock. While one cycle is outstanding, a second strobe is allowed only after the system has signalled with a next-address pulse that it will accept a pipelined cycle. That pulse is sampled only inside a defined window. When it is seen, it is latched, so one clock of assertion is enough. If the pulse arrives while two cycles are outstanding, it is kept until the oldest cycle finishes. Burst-ready returns always count against the oldest cycle.

A requester holds its request and beat size stable until it sees the address strobe. The strobe is the acceptance of that request.

Top module: `pbi_issue_ctl`

## Requirements
- R1: With no cycle outstanding and the strobe low, a request sampled at a clock edge drives `ads_o` high for the following clock, and `outst_o` becomes 1.
- R2: `ads_o` is high for exactly one clock per issued cycle, and it never rises unless `req_i` was high at the edge that raised it.
- R3: `outst_o` never exceeds 2. No strobe is issued at an edge where two cycles are outstanding.
- R4: A cycle whose `req_burst_i` was 1 at issue is owed `BURST_BEATS` (default 4) burst-ready returns. A cycle whose `req_burst_i` was 0 is owed 1. A cycle completes at the edge that samples its last return, and `outst_o` drops by one there. Returns go to the oldest cycle. A return is ignored when no cycle is outstanding, and it is also ignored at an edge where the only outstanding cycle is still driving its own strobe.
- R5: With one cycle outstanding and a request pending, a next-address pulse sampled at edge N causes the pipelined strobe to be issued at edge N+1. `ads_o` is then high in the following clock and `outst_o` becomes 2.
- R6: Next-address is not sampled at any edge where `ads_o` is high. For a cycle issued from idle, sampling starts two edges after the issuing edge. For a pipelined cycle, it starts three edges after the issuing edge. A pulse outside the window has no effect on later strobes.
- R7: A one-clock next-address pulse inside the window is remembered until it is used, so the pipelined strobe can follow later when a request arrives.
- R8: A next-address pulse sampled while two cycles are outstanding is held. The pipelined strobe is issued at the edge after the oldest cycle completes.
- R9: The remembered next-address clears when the pipelined strobe it enabled is issued, and when the outstanding count reaches zero. After either, a request made while one cycle is outstanding waits for a fresh pulse.
- R10: Synchronous active-high `rst` forces `ads_o` to 0, `busy_o` to 0 and `outst_o` to 0 at the next edge, discarding all outstanding cycles and the remembered next-address.
- R11: `busy_o` is high exactly when `outst_o` is non-zero, and `ads_o` is only high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request to start a bus cycle, held until the strobe is seen |
| req_burst_i | input | 1 | Beat size of the request: 1 means `BURST_BEATS` returns, 0 means one |
| na_i | input | 1 | Next-address from system logic, active high, may last one clock |
| brdy_i | input | 1 | Burst-ready return from system logic, active high |
| ads_o | output | 1 | Address strobe, one clock per issued cycle |
| busy_o | output | 1 | At least one cycle outstanding |
| outst_o | output | 2 | Number of outstanding cycles, 0 to 2 |

## Verification
The checker assumes that a requester keeps `req_i` high from the moment it asks until it sees `ads_o`, and drops it or presents a new request only after that. The property that a strobe never rises without a request depends on this. Burst-ready and next-address are not assumed to follow any protocol. The block must ignore them outside cycles and outside the sampling window, so the random stimulus pulses both freely, including while the bus is idle. The random requester obeys the hold-until-strobe rule exactly and picks its beat size at random.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
   localparam int unsigned PBI_MAX_OUT = 2;
   localparam int unsigned PBI_CNT_W   = $clog2(PBI_MAX_OUT + 1);
   typedef logic [PBI_CNT_W-1:0] pbi_cnt_t;
endpackage

// File: rtl/pbi_beat_queue.sv
// Two-slot in-order queue of beats still owed per outstanding cycle.
// Slot 0 is always the oldest cycle.
module pbi_beat_queue
   import pbi_pkg::*;
#(
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push_i,
   input  logic [CW-1:0] push_beats_i,
   input  logic          credit_i,
   output logic          done_o,
   output pbi_cnt_t      cnt_o,
   output pbi_cnt_t      cnt_nxt_o
);
   logic [CW-1:0] rem_q [PBI_MAX_OUT];
   pbi_cnt_t      cnt_q;
   pbi_cnt_t      wr_idx;

   always_comb begin
      done_o    = credit_i && (rem_q[0] == CW'(1));
      wr_idx    = cnt_q - pbi_cnt_t'(done_o);
      cnt_nxt_o = cnt_q + pbi_cnt_t'(push_i) - pbi_cnt_t'(done_o);
   end

   assign cnt_o = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_nxt_o;
   end

   for (genvar i = 0; i < PBI_MAX_OUT; i++) begin : g_slot
      logic [CW-1:0] shift_in;
      logic          is_wr;

      if (i + 1 < PBI_MAX_OUT) begin : g_mid
         assign shift_in = rem_q[i+1];
      end else begin : g_last
         assign shift_in = '0;
      end

      assign is_wr = push_i && (wr_idx == pbi_cnt_t'(i));

      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)           rem_q[i] <= '0;
            else if (is_wr)    rem_q[i] <= push_beats_i;
            else if (done_o)   rem_q[i] <= shift_in;
            else if (credit_i) rem_q[i] <= rem_q[i] - CW'(1);
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst)         rem_q[i] <= '0;
            else if (is_wr)  rem_q[i] <= push_beats_i;
            else if (done_o) rem_q[i] <= shift_in;
         end
      end
   end
endmodule

// File: rtl/pbi_na_window.sv
// Sampling window and latch for the next-address input.
module pbi_na_window (
   input  logic clk,
   input  logic rst,
   input  logic busy_i,
   input  logic ads_i,
   input  logic pipe_issue_i,
   input  logic idle_nxt_i,
   input  logic na_i,
   output logic na_lat_o
);
   logic pipe_q;
   logic gap_q;
   logic na_q;
   logic sample_en;

   // No sampling while a strobe is out, nor on the edge after a
   // pipelined strobe has been withdrawn.
   assign sample_en = busy_i && !ads_i && !gap_q;
   assign na_lat_o  = na_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pipe_q <= 1'b0;
         gap_q  <= 1'b0;
         na_q   <= 1'b0;
      end else begin
         pipe_q <= pipe_issue_i;
         gap_q  <= pipe_q;
         if (pipe_issue_i || idle_nxt_i) na_q <= 1'b0;
         else if (sample_en && na_i)     na_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pbi_issue_ctl.sv
module pbi_issue_ctl
   import pbi_pkg::*;
#(
   parameter int unsigned BURST_BEATS = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       req_i,
   input  logic       req_burst_i,
   input  logic       na_i,
   input  logic       brdy_i,
   output logic       ads_o,
   output logic       busy_o,
   output logic [1:0] outst_o
);
   localparam int unsigned CW = $clog2(BURST_BEATS + 1);

   initial begin
      assert (BURST_BEATS >= 2 && BURST_BEATS <= 64)
         else $error("pbi_issue_ctl: BURST_BEATS must lie in 2..64");
   end

   logic          ads_q;
   logic          issue;
   logic          pipe_issue;
   logic          credit;
   logic          done;
   logic          na_lat;
   logic [CW-1:0] push_beats;
   pbi_cnt_t      cnt;
   pbi_cnt_t      cnt_nxt;

   always_comb begin
      issue      = req_i && !ads_q &&
                   ((cnt == '0) || ((cnt == pbi_cnt_t'(1)) && na_lat));
      pipe_issue = issue && (cnt == pbi_cnt_t'(1));
      credit     = brdy_i && (cnt != '0) &&
                   !(ads_q && (cnt == pbi_cnt_t'(1)));
      push_beats = req_burst_i ? CW'(BURST_BEATS) : CW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) ads_q <= 1'b0;
      else     ads_q <= issue;
   end

   pbi_beat_queue #(.CW(CW)) u_queue (
      .clk          (clk),
      .rst          (rst),
      .push_i       (issue),
      .push_beats_i (push_beats),
      .credit_i     (credit),
      .done_o       (done),
      .cnt_o        (cnt),
      .cnt_nxt_o    (cnt_nxt)
   );

   pbi_na_window u_window (
      .clk          (clk),
      .rst          (rst),
      .busy_i       (cnt != '0),
      .ads_i        (ads_q),
      .pipe_issue_i (pipe_issue),
      .idle_nxt_i   (cnt_nxt == '0),
      .na_i         (na_i),
      .na_lat_o     (na_lat)
   );

   assign ads_o   = ads_q;
   assign busy_o  = (cnt != '0);
   assign outst_o = 2'(cnt);
endmodule

// File: rtl/pbi_issue_chk.sv
module pbi_issue_chk (
   input logic       clk,
   input logic       rst,
   input logic       req_i,
   input logic       ads_o,
   input logic       busy_o,
   input logic [1:0] outst_o
);
   // R3
   outst_limit_chk: assert property (@(posedge clk) disable iff (rst)
      outst_o != 2'd3);

   // R3
   full_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (outst_o == 2'd2) |=> !ads_o);

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
      ads_o |=> !ads_o);

   // R2
   strobe_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ads_o) |-> $past(req_i));

   // R1
   idle_issue_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && !ads_o && req_i) |=> (ads_o && outst_o == 2'd1));

   // R11
   strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
      ads_o |-> busy_o);
endmodule

bind pbi_issue_ctl pbi_issue_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .req_i   (req_i),
   .ads_o   (ads_o),
   .busy_o  (busy_o),
   .outst_o (outst_o)
);

// File: tb/pbi_issue_ctl_tb.sv
`timescale 1ns/1ps
module pbi_issue_ctl_tb;
   localparam int BEATS = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_r = 1'b0, burst_r = 1'b0, na_r = 1'b0, brdy_r = 1'b0;
   logic       ads_w, busy_w;
   logic [1:0] outst_w;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   // reference state
   int m_cnt, m_r0, m_r1;
   bit m_ads, m_pipe, m_gap, m_na;

   always #2.5 clk = ~clk;

   pbi_issue_ctl #(.BURST_BEATS(BEATS)) u_dut (
      .clk(clk), .rst(rst), .req_i(req_r), .req_burst_i(burst_r),
      .na_i(na_r), .brdy_i(brdy_r),
      .ads_o(ads_w), .busy_o(busy_w), .outst_o(outst_w)
   );

   function automatic int beats_of(input bit b);
      return b ? BEATS : 1;
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_r0 = 0; m_r1 = 0;
      m_ads = 0; m_pipe = 0; m_gap = 0; m_na = 0;
   endtask

   task automatic model_step();
      bit issue, pipe, credit, done, samp;
      int nc;
      issue  = req_r && !m_ads && (m_cnt == 0 || (m_cnt == 1 && m_na));
      pipe   = issue && m_cnt == 1;
      credit = brdy_r && m_cnt != 0 && !(m_ads && m_cnt == 1);
      done   = credit && m_r0 == 1;
      samp   = m_cnt != 0 && !m_ads && !m_gap;
      if (done) begin m_r0 = m_r1; m_r1 = 0; end
      else if (credit) m_r0 = m_r0 - 1;
      if (issue) begin
         if (m_cnt - int'(done) == 0) m_r0 = beats_of(burst_r);
         else                         m_r1 = beats_of(burst_r);
      end
      nc = m_cnt + int'(issue) - int'(done);
      if (pipe || nc == 0) m_na = 0;
      else if (samp && na_r) m_na = 1;
      m_gap  = m_pipe;
      m_pipe = pipe;
      m_ads  = issue;
      m_cnt  = nc;
   endtask

   task automatic tick(input bit r, input bit b, input bit n, input bit d);
      req_r = r; burst_r = b; na_r = n; brdy_r = d;
      @(posedge clk);
      if (rst) model_reset(); else model_step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input bit e_ads, input int e_out);
      n_chk++;
      if (ads_w !== e_ads || int'(outst_w) != e_out || busy_w !== (e_out != 0)) begin
         n_bad++;
         $display("FAIL %s: ads=%0b outst=%0d busy=%0b expected ads=%0b outst=%0d busy=%0b",
                  tag, ads_w, outst_w, busy_w, e_ads, e_out, e_out != 0);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      @(negedge clk);
      rst = 1'b1;
      tick(0,0,0,0); tick(0,0,0,0);
      chk("R10 reset state", 0, 0);
      rst = 1'b0;

      // S1: idle issue, strobe width, return ignored during lone strobe
      tick(1,0,0,0); chk("R1 idle issue", 1, 1);
      tick(0,0,0,1); chk("R4 return ignored during own strobe", 0, 1);
      tick(0,0,0,1); chk("R4 single return completes", 0, 0);

      // S2: window, latch, exclusion after pipelined strobe, clearing
      tick(1,1,0,0); chk("R1 burst issue", 1, 1);
      tick(1,0,1,0); chk("R6 na ignored while strobe high", 0, 1);
      tick(1,0,0,0); chk("R6 no issue without sampled na", 0, 1);
      tick(1,0,1,0); chk("R7 na latched, not yet issued", 0, 1);
      tick(1,0,0,0); chk("R5 pipelined strobe after na", 1, 2);
      tick(0,0,0,0); chk("R2 strobe one clock", 0, 2);
      tick(1,0,1,0); chk("R3 no strobe with two outstanding", 0, 2);
      tick(1,0,0,1); chk("R4 burst beat 1", 0, 2);
      tick(1,0,0,1); chk("R4 burst beat 2", 0, 2);
      tick(1,0,0,1); chk("R4 burst beat 3", 0, 2);
      tick(1,0,0,1); chk("R4 burst completes on fourth return", 0, 1);
      tick(1,0,0,0); chk("R6 na at excluded edge had no effect", 0, 1);
      tick(1,0,1,0); chk("R7 na latched again", 0, 1);
      tick(1,0,0,0); chk("R5 second pipelined strobe", 1, 2);
      tick(0,0,0,1); chk("R4 return credited to oldest", 0, 1);
      tick(1,0,0,0); chk("R9 flag cleared by pipelined issue", 0, 1);
      tick(1,0,0,0); chk("R9 still waiting for fresh na", 0, 1);
      tick(1,0,0,1); chk("R11 drained to idle", 0, 0);
      tick(1,0,0,0); chk("R1 idle issue after drain", 1, 1);
      tick(0,0,0,1); chk("R4 ignored during lone strobe", 0, 1);
      tick(0,0,0,1); chk("R11 idle again", 0, 0);

      // S3: na held while two outstanding
      tick(1,0,0,0); chk("R1 issue", 1, 1);
      tick(1,0,0,0); chk("R2 blocked while strobe high", 0, 1);
      tick(1,0,1,0); chk("R7 latch for first cycle window", 0, 1);
      tick(1,0,0,0); chk("R5 pipelined", 1, 2);
      tick(1,0,0,0); chk("R3 full", 0, 2);
      tick(1,0,1,0); chk("R6 excluded edge after pipelined strobe", 0, 2);
      tick(1,0,1,0); chk("R8 na latched while full", 0, 2);
      tick(1,0,0,0); chk("R8 held back while full", 0, 2);
      tick(1,0,0,1); chk("R8 oldest completes", 0, 1);
      tick(1,0,0,0); chk("R8 held strobe issued", 1, 2);
      tick(0,0,0,1); chk("R4 oldest single completes", 0, 1);
      tick(0,0,0,1); chk("R4 last completes", 0, 0);

      // S4: flag cleared on idle
      tick(1,0,0,0); chk("R1 issue", 1, 1);
      tick(0,0,0,0); chk("R2 strobe dropped", 0, 1);
      tick(0,0,1,0); chk("R7 na latched with no request", 0, 1);
      tick(0,0,0,1); chk("R9 drain to idle", 0, 0);
      tick(1,0,0,0); chk("R1 issue from idle", 1, 1);
      tick(1,0,0,0); chk("R9 blocked by strobe", 0, 1);
      tick(1,0,0,0); chk("R9 idle cleared flag", 0, 1);

      // mid-activity reset
      rst = 1'b1;
      tick(1,0,0,0); chk("R10 reset discards cycles", 0, 0);
      rst = 1'b0;
      tick(0,0,0,0); chk("R10 stays idle", 0, 0);

      // random phase against reference
      for (int i = 0; i < 4000; i++) begin
         bit r, b;
         r = req_r; b = burst_r;
         if (ads_w) r = 1'b0;
         if (!r && ($urandom % 3 == 0)) begin r = 1'b1; b = 1'($urandom % 2); end
         tick(r, b, ($urandom % 4 == 0), ($urandom % 3 == 0));
         chk("R3 R4 R5 R6 R8 R9 random vs reference", m_ads, m_cnt);
      end
      summary();
   end
endmodule